// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a configuration bus. It turns two programmed-I/O ports inside an 8-byte window into single configuration requests toward a downstream target. Software first writes a 32-bit address word to the address port at window offset 0. That word carries an enable bit, a bus number, a device number, a function number and a dword register index. Software then makes exactly one access to the data port, which covers window offsets 4 to 7.

The data access may be 1, 2 or 4 bytes wide. Its byte offset k inside the data port selects byte k of the addressed dword. The bridge derives the byte enables from k and the access width. It moves write data up into the addressed lanes, and it moves read data from the addressed lanes down into the low end of the host data bus, little-endian.

The bridge has three ways to answer without a bus cycle:
- A misaligned access is rejected with an error flag.
- An access made while the enable bit is clear is answered locally.
- A target that never acknowledges is cut off by a timeout and completed with all-ones data.

The host issues one access at a time and waits for the completion pulse before it issues the next.

Top module: `cfg_port_bridge`

## Requirements
- R1: An address-port write (`pio_off` = 0, size code 2) stores the word. A 4-byte read at offset 0 returns bit 31 and bits 23:2 as written, with bits 30:24 and 1:0 read as zero. The value after reset is 0.
- R2: Every configuration request carries fields taken from the stored address word: `cfg_bus` = bits 23:16, `cfg_dev` = bits 15:11, `cfg_func` = bits 10:8 and `cfg_reg` = bits 7:2 (the dword index).
- R3: The size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. For a data access at `pio_off` = 4 + k, `cfg_be` equals (2^bytes − 1) shifted left by k.
- R4: On a write request, `cfg_wdata` equals `pio_wdata` shifted left by 8·k bits, so byte 0 of the host data lands in lane k.
- R5: A completed read returns the target dword shifted right by 8·k bits on `pio_rdata`, with every byte above the access width forced to zero. Write completions return 0.
- R6: The following accesses are rejected: a 2-byte access at k = 3, a 4-byte access at k ≠ 0, size code 3, and any address-port access that is not 4 bytes at offset 0. A rejected access completes with `pio_err` = 1 and `pio_rdata` = 0, issues no request and leaves the stored address unchanged.
- R7: While bit 31 of the stored address is 0, data reads return all ones in the access width (zero above it), data writes are dropped, and no request is issued.
- R8: Each legal, enabled data access issues exactly one request. `cfg_valid` rises one cycle after the accepted `pio_req`, and it holds with stable fields, byte enables and write data until the cycle in which `cfg_ack` is sampled high.
- R9: If no acknowledge arrives, `cfg_valid` stays high for exactly TIMEOUT_CYC cycles. The access then completes without error, and a read returns all ones in the access width.
- R10: After reset `pio_ready` and `cfg_valid` are 0. Each access produces exactly one single-cycle `pio_ready` pulse, and `pio_ready` is never high while `cfg_valid` is high. Local accesses complete one cycle after `pio_req`; bus accesses complete one cycle after the acknowledge or timeout cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pio_req | input | 1 | One-cycle host access strobe |
| pio_we | input | 1 | 1 = host write, 0 = host read |
| pio_off | input | 3 | Byte offset inside the 8-byte window |
| pio_size | input | 2 | Access size code (0 = 1 B, 1 = 2 B, 2 = 4 B) |
| pio_wdata | input | 32 | Host write data, right-aligned |
| pio_ready | output | 1 | Completion pulse |
| pio_err | output | 1 | Access rejected, valid with pio_ready |
| pio_rdata | output | 32 | Host read data, right-aligned, valid with pio_ready |
| cfg_valid | output | 1 | Configuration request pending |
| cfg_write | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_func | output | 3 | Target function number |
| cfg_reg | output | 6 | Target dword register index |
| cfg_be | output | 4 | Byte enables for the dword |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Target acknowledge, sampled with cfg_valid |
| cfg_rdata | input | 32 | Target read dword, valid with cfg_ack |

## Verification
The byte, halfword and word accesses are placed at every legal offset into one dword that was first built up by partial writes. This tells a lane-shift error apart from a byte-enable error and from a missing zero-fill above the access width. Two address words with different field values, paired with acknowledge delays of zero, one and three cycles, separate field-extraction mistakes from handshake-hold mistakes. Each misaligned shape, each disabled access and each access to a never-answering device is followed by a request count and a readback through the normal ports, which shows that nothing reached the target.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
   localparam int DW     = 32;
   localparam int LANES  = DW / 8;
   localparam int LANE_W = $clog2(LANES);
   localparam int BUS_W  = 8;
   localparam int DEV_W  = 5;
   localparam int FUNC_W = 3;
   localparam int REG_W  = 6;
   // bits of the address word that are stored; the rest read back as zero
   localparam logic [DW-1:0] ADDR_KEEP = 32'h80FF_FFFC;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef struct packed {
      logic [BUS_W-1:0]  bus;
      logic [DEV_W-1:0]  dev;
      logic [FUNC_W-1:0] func;
      logic [REG_W-1:0]  dw_idx;
   } cfg_tgt_t;

   function automatic cfg_tgt_t decode_addr(input logic [DW-1:0] a);
      cfg_tgt_t t;
      t.bus    = a[23:16];
      t.dev    = a[15:11];
      t.func   = a[10:8];
      t.dw_idx = a[7:2];
      return t;
   endfunction

   function automatic logic [LANE_W:0] size_bytes(input acc_size_e s);
      logic [LANE_W:0] n;
      unique case (s)
         SZ_BYTE: n = (LANE_W+1)'(1);
         SZ_HALF: n = (LANE_W+1)'(2);
         SZ_WORD: n = (LANE_W+1)'(4);
         default: n = '0;
      endcase
      return n;
   endfunction
endpackage

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg
   import cfgb_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] addr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= '0;
      else if (wr_en)
         addr_q <= wdata & ADDR_KEEP;
   end

   AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (addr_q[31] == $past(wdata[31])) && (addr_q[23:2] == $past(wdata[23:2]))); // R1
endmodule

// File: rtl/cfgb_lane_steer.sv
module cfgb_lane_steer
   import cfgb_pkg::*;
(
   input  acc_size_e         size,
   input  logic [LANE_W-1:0] lane,
   input  logic [DW-1:0]     wdata_in,
   output logic              legal,
   output logic [LANES-1:0]  be,
   output logic [DW-1:0]     wdata_out
);
   logic [LANE_W:0] nb;
   logic [LANE_W:0] lo;
   logic [LANE_W:0] hi;

   always_comb begin
      nb    = size_bytes(size);
      lo    = {1'b0, lane};
      hi    = lo + nb;
      legal = (nb != '0) && (hi <= (LANE_W+1)'(LANES));
   end

   for (genvar i = 0; i < LANES; i++) begin : g_be
      localparam logic [LANE_W:0] IDX = (LANE_W+1)'(i);
      assign be[i] = legal && (IDX >= lo) && (IDX < hi);
   end

   assign wdata_out = wdata_in << {lane, 3'b000};
endmodule

// File: rtl/cfgb_rd_align.sv
module cfgb_rd_align
   import cfgb_pkg::*;
(
   input  acc_size_e         size,
   input  logic [LANE_W-1:0] lane,
   input  logic [DW-1:0]     din,
   output logic [DW-1:0]     dout
);
   logic [LANE_W:0] nb;
   logic [DW-1:0]   keep;

   assign nb = size_bytes(size);

   for (genvar i = 0; i < LANES; i++) begin : g_keep
      localparam logic [LANE_W:0] IDX = (LANE_W+1)'(i);
      assign keep[8*i +: 8] = {8{IDX < nb}};
   end

   assign dout = (din >> {lane, 3'b000}) & keep;
endmodule

// File: rtl/cfgb_txn_fsm.sv
module cfgb_txn_fsm
   import cfgb_pkg::*;
#(
   parameter int TIMEOUT_CYC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_we,
   input  logic [LANES-1:0] start_be,
   input  logic [DW-1:0]    start_wdata,
   input  cfg_tgt_t         start_tgt,
   input  logic             cfg_ack,
   output logic             cfg_valid,
   output logic             cfg_write,
   output logic [LANES-1:0] cfg_be,
   output logic [DW-1:0]    cfg_wdata,
   output cfg_tgt_t         cfg_tgt,
   output logic             done,
   output logic             done_tmo
);
   localparam int TMO_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;

   if (TIMEOUT_CYC == 1 || TIMEOUT_CYC < 0) begin : g_bad_tmo
      $error("TIMEOUT_CYC must be 0 (no timeout) or at least 2");
   end

   logic [TMO_W-1:0] cnt_q;
   logic             tmo_hit;

   if (TIMEOUT_CYC == 0) begin : g_no_tmo
      assign tmo_hit = 1'b0;
   end else begin : g_tmo
      localparam logic [TMO_W-1:0] LAST = TMO_W'(TIMEOUT_CYC - 1);
      assign tmo_hit = (cnt_q == LAST);

      AST_TIMEOUT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_valid && !cfg_ack && cnt_q == LAST) |=> !cfg_valid); // R9
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_valid <= 1'b0;
         cfg_write <= 1'b0;
         cfg_be    <= '0;
         cfg_wdata <= '0;
         cfg_tgt   <= '0;
         cnt_q     <= '0;
      end else if (!cfg_valid) begin
         if (start) begin
            cfg_valid <= 1'b1;
            cfg_write <= start_we;
            cfg_be    <= start_be;
            cfg_wdata <= start_wdata;
            cfg_tgt   <= start_tgt;
            cnt_q     <= '0;
         end
      end else if (cfg_ack || tmo_hit) begin
         cfg_valid <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done     = cfg_valid && (cfg_ack || tmo_hit);
   assign done_tmo = cfg_valid && !cfg_ack && tmo_hit;

   AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !cfg_ack && !tmo_hit) |=>
         (cfg_valid && $stable(cfg_be) && $stable(cfg_tgt) && $stable(cfg_wdata) && $stable(cfg_write))); // R8
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
   import cfgb_pkg::*;
#(
   parameter int TIMEOUT_CYC = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pio_req,
   input  logic        pio_we,
   input  logic [2:0]  pio_off,
   input  logic [1:0]  pio_size,
   input  logic [31:0] pio_wdata,
   output logic        pio_ready,
   output logic        pio_err,
   output logic [31:0] pio_rdata,
   output logic        cfg_valid,
   output logic        cfg_write,
   output logic [7:0]  cfg_bus,
   output logic [4:0]  cfg_dev,
   output logic [2:0]  cfg_func,
   output logic [5:0]  cfg_reg,
   output logic [3:0]  cfg_be,
   output logic [31:0] cfg_wdata,
   input  logic        cfg_ack,
   input  logic [31:0] cfg_rdata
);
   acc_size_e         req_size;
   logic [LANE_W-1:0] req_lane;
   logic              is_data;
   logic              accept;
   logic              addr_ok;
   logic              addr_wr;
   logic              fsm_start;
   logic [DW-1:0]     addr_q;
   logic              legal;
   logic [LANES-1:0]  req_be;
   logic [DW-1:0]     req_wdata;
   logic              fsm_done;
   logic              fsm_tmo;
   cfg_tgt_t          tgt;

   acc_size_e         pend_size;
   logic [LANE_W-1:0] pend_lane;
   logic              pend_we;
   acc_size_e         al_size;
   logic [LANE_W-1:0] al_lane;
   logic [DW-1:0]     al_din;
   logic [DW-1:0]     al_dout;

   assign req_size  = acc_size_e'(pio_size);
   assign req_lane  = pio_off[LANE_W-1:0];
   assign is_data   = pio_off[2];
   assign accept    = pio_req && !cfg_valid;
   assign addr_ok   = (req_size == SZ_WORD) && (req_lane == '0);
   assign addr_wr   = accept && !is_data && addr_ok && pio_we;
   assign fsm_start = accept && is_data && legal && addr_q[31];

   cfgb_addr_reg u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (addr_wr),
      .wdata  (pio_wdata),
      .addr_q (addr_q)
   );

   cfgb_lane_steer u_steer (
      .size      (req_size),
      .lane      (req_lane),
      .wdata_in  (pio_wdata),
      .legal     (legal),
      .be        (req_be),
      .wdata_out (req_wdata)
   );

   cfgb_txn_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (fsm_start),
      .start_we    (pio_we),
      .start_be    (req_be),
      .start_wdata (req_wdata),
      .start_tgt   (decode_addr(addr_q)),
      .cfg_ack     (cfg_ack),
      .cfg_valid   (cfg_valid),
      .cfg_write   (cfg_write),
      .cfg_be      (cfg_be),
      .cfg_wdata   (cfg_wdata),
      .cfg_tgt     (tgt),
      .done        (fsm_done),
      .done_tmo    (fsm_tmo)
   );

   assign cfg_bus  = tgt.bus;
   assign cfg_dev  = tgt.dev;
   assign cfg_func = tgt.func;
   assign cfg_reg  = tgt.dw_idx;

   // one aligner: the pending access while busy, the local all-ones answer when idle
   always_comb begin
      if (cfg_valid) begin
         al_size = pend_size;
         al_lane = pend_lane;
         al_din  = fsm_tmo ? '1 : cfg_rdata;
      end else begin
         al_size = req_size;
         al_lane = req_lane;
         al_din  = '1;
      end
   end

   cfgb_rd_align u_align (
      .size (al_size),
      .lane (al_lane),
      .din  (al_din),
      .dout (al_dout)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pio_ready <= 1'b0;
         pio_err   <= 1'b0;
         pio_rdata <= '0;
         pend_size <= SZ_BYTE;
         pend_lane <= '0;
         pend_we   <= 1'b0;
      end else begin
         pio_ready <= 1'b0;
         pio_err   <= 1'b0;
         if (fsm_done) begin
            pio_ready <= 1'b1;
            pio_rdata <= pend_we ? '0 : al_dout;
         end else if (accept) begin
            if (!is_data) begin
               pio_ready <= 1'b1;
               pio_err   <= !addr_ok;
               pio_rdata <= (addr_ok && !pio_we) ? addr_q : '0;
            end else if (!legal) begin
               pio_ready <= 1'b1;
               pio_err   <= 1'b1;
               pio_rdata <= '0;
            end else if (!addr_q[31]) begin
               pio_ready <= 1'b1;
               pio_rdata <= pio_we ? '0 : al_dout;
            end else begin
               pend_size <= req_size;
               pend_lane <= req_lane;
               pend_we   <= pio_we;
            end
         end
      end
   end

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      pio_ready |-> !cfg_valid); // R10
   AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pio_err |-> (pio_ready && !cfg_valid)); // R6
   AST_CYCLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_valid) |-> addr_q[31]); // R7
   AST_CYCLE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_valid) |-> $past(pio_req)); // R8
   AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> (cfg_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h6, 4'hC, 4'hF})); // R3
endmodule

// File: tb/tb_cfg_port_bridge.sv
module tb_cfg_port_bridge;
   localparam int TMO = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pio_req = 1'b0;
   logic        pio_we = 1'b0;
   logic [2:0]  pio_off = '0;
   logic [1:0]  pio_size = '0;
   logic [31:0] pio_wdata = '0;
   logic        pio_ready;
   logic        pio_err;
   logic [31:0] pio_rdata;
   logic        cfg_valid;
   logic        cfg_write;
   logic [7:0]  cfg_bus;
   logic [4:0]  cfg_dev;
   logic [2:0]  cfg_func;
   logic [5:0]  cfg_reg;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata;
   logic        cfg_ack = 1'b0;
   logic [31:0] cfg_rdata = '0;

   always #2 clk = ~clk;

   cfg_port_bridge #(.TIMEOUT_CYC(TMO)) dut (
      .clk(clk), .rst_n(rst_n),
      .pio_req(pio_req), .pio_we(pio_we), .pio_off(pio_off), .pio_size(pio_size),
      .pio_wdata(pio_wdata), .pio_ready(pio_ready), .pio_err(pio_err), .pio_rdata(pio_rdata),
      .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
      .cfg_func(cfg_func), .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
   );

   int checks = 0;
   int failures = 0;
   int issued = 0;
   int completions = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- target model ----------------
   logic [31:0] tgt_mem [64];
   logic [31:0] ref_mem [64];
   int          ack_delay = 0;
   int          wait_cnt = 0;
   int          req_count = 0;
   int          valid_len = 0;
   logic        prev_valid = 1'b0;
   logic [7:0]  last_bus;
   logic [4:0]  last_dev;
   logic [2:0]  last_func;
   logic [5:0]  last_reg;
   logic [3:0]  last_be;
   logic [31:0] last_wdata;
   logic        last_write;
   logic [31:0] merge;

   always @(posedge clk) begin
      if (!rst_n) begin
         cfg_ack  <= 1'b0;
         wait_cnt <= 0;
      end else if (cfg_ack) begin
         cfg_ack  <= 1'b0;
         wait_cnt <= 0;
      end else if (cfg_valid && cfg_dev != 5'd31) begin
         if (wait_cnt >= ack_delay) begin
            cfg_ack    <= 1'b1;
            cfg_rdata  <= tgt_mem[cfg_reg];
            last_bus   <= cfg_bus;
            last_dev   <= cfg_dev;
            last_func  <= cfg_func;
            last_reg   <= cfg_reg;
            last_be    <= cfg_be;
            last_wdata <= cfg_wdata;
            last_write <= cfg_write;
            if (cfg_write) begin
               merge = tgt_mem[cfg_reg];
               for (int i = 0; i < 4; i++)
                  if (cfg_be[i]) merge[8*i +: 8] = cfg_wdata[8*i +: 8];
               tgt_mem[cfg_reg] <= merge;
            end
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         if (cfg_valid && !prev_valid) req_count <= req_count + 1;
         if (cfg_valid) valid_len <= prev_valid ? valid_len + 1 : 1;
         prev_valid <= cfg_valid;
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [31:0] rdata;
      logic        err;
      string       tag;
   } sb_item_t;
   sb_item_t sb_q [$];
   logic ready_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (pio_ready) begin
            completions++;
            if (sb_q.size() == 0) begin
               chk(1'b0, "R10 completion without access", 32'(pio_ready), 32'h0);
            end else begin
               sb_item_t it;
               it = sb_q.pop_front();
               chk(pio_rdata == it.rdata, it.tag, pio_rdata, it.rdata);
               chk(pio_err == it.err, {it.tag, " err"}, 32'(pio_err), 32'(it.err));
            end
         end
         if (pio_ready && ready_prev)
            chk(1'b0, "R10 ready longer than one cycle", 32'h1, 32'h0);
         ready_prev = pio_ready;
      end
   end

   // size codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes
   function automatic logic [3:0] be_of(input logic [1:0] sz, input logic [1:0] k);
      logic [3:0] m;
      m = (sz == 2'd0) ? 4'h1 : (sz == 2'd1) ? 4'h3 : 4'hF;
      return m << k;
   endfunction

   function automatic logic [31:0] width_ones(input logic [1:0] sz);
      return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   task automatic access(input logic we, input logic [2:0] off, input logic [1:0] sz,
                         input logic [31:0] wd, input logic exp_err,
                         input logic [31:0] exp_rd, input string tag);
      sb_item_t it;
      it.rdata = exp_rd;
      it.err   = exp_err;
      it.tag   = tag;
      sb_q.push_back(it);
      issued++;
      @(negedge clk);
      pio_req   = 1'b1;
      pio_we    = we;
      pio_off   = off;
      pio_size  = sz;
      pio_wdata = wd;
      @(negedge clk);
      pio_req = 1'b0;
      while (!pio_ready) @(negedge clk);
   endtask

   task automatic ref_write(input logic [5:0] idx, input logic [1:0] sz, input logic [1:0] k,
                            input logic [31:0] wd);
      logic [3:0]  be;
      logic [31:0] sh;
      be = be_of(sz, k);
      sh = wd << (8 * k);
      for (int i = 0; i < 4; i++)
         if (be[i]) ref_mem[idx][8*i +: 8] = sh[8*i +: 8];
   endtask

   function automatic logic [31:0] ref_read(input logic [5:0] idx, input logic [1:0] sz,
                                            input logic [1:0] k);
      return (ref_mem[idx] >> (8 * k)) & width_ones(sz);
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int rc;
      for (int i = 0; i < 64; i++) begin
         tgt_mem[i] = '0;
         ref_mem[i] = '0;
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pio_ready == 1'b0, "R10 reset pio_ready", 32'(pio_ready), 32'h0);
      chk(cfg_valid == 1'b0, "R10 reset cfg_valid", 32'(cfg_valid), 32'h0);

      // R1 address register
      access(1'b0, 3'd0, 2'd2, 32'h0, 1'b0, 32'h0, "R1 reset address value");
      access(1'b1, 3'd0, 2'd2, 32'hFFFF_FFFF, 1'b0, 32'h0, "R1 write all ones");
      access(1'b0, 3'd0, 2'd2, 32'h0, 1'b0, 32'h80FF_FFFC, "R1 readback masks");
      access(1'b1, 3'd0, 2'd2, 32'hFF12_1D43, 1'b0, 32'h0, "R1 write addr A");
      access(1'b0, 3'd0, 2'd2, 32'h0, 1'b0, 32'h8012_1D40, "R1 readback addr A");

      // R2 R3 R4 writes, ack immediately
      ack_delay = 0;
      rc = req_count;
      access(1'b1, 3'd4, 2'd2, 32'hA1B2_C3D4, 1'b0, 32'h0, "R4 word write");
      ref_write(6'h10, 2'd2, 2'd0, 32'hA1B2_C3D4);
      chk(req_count == rc + 1, "R8 one request per access", 32'(req_count), 32'(rc + 1));
      chk(last_bus == 8'h12, "R2 bus field", 32'(last_bus), 32'h12);
      chk(last_dev == 5'd3, "R2 device field", 32'(last_dev), 32'h3);
      chk(last_func == 3'd5, "R2 function field", 32'(last_func), 32'h5);
      chk(last_reg == 6'h10, "R2 register index", 32'(last_reg), 32'h10);
      chk(last_be == 4'hF, "R3 word enables", 32'(last_be), 32'hF);
      chk(last_write == 1'b1, "R8 write flag", 32'(last_write), 32'h1);
      chk(last_wdata == 32'hA1B2_C3D4, "R4 word data", last_wdata, 32'hA1B2_C3D4);

      access(1'b1, 3'd6, 2'd0, 32'h0000_005A, 1'b0, 32'h0, "R4 byte write k2");
      ref_write(6'h10, 2'd0, 2'd2, 32'h5A);
      chk(last_be == be_of(2'd0, 2'd2), "R3 byte enables k2", 32'(last_be), 32'(be_of(2'd0, 2'd2)));
      chk(last_wdata == 32'h005A_0000, "R4 byte lane k2", last_wdata, 32'h005A_0000);

      access(1'b1, 3'd5, 2'd1, 32'h0000_7788, 1'b0, 32'h0, "R4 half write k1");
      ref_write(6'h10, 2'd1, 2'd1, 32'h7788);
      chk(last_be == 4'h6, "R3 half enables k1", 32'(last_be), 32'h6);
      chk(last_wdata == 32'h0077_8800, "R4 half lane k1", last_wdata, 32'h0077_8800);

      // R5 reads with a slow target
      ack_delay = 3;
      rc = req_count;
      access(1'b0, 3'd4, 2'd2, 32'h0, 1'b0, ref_read(6'h10, 2'd2, 2'd0), "R5 word read");
      chk(req_count == rc + 1, "R8 one request slow ack", 32'(req_count), 32'(rc + 1));
      chk(last_write == 1'b0, "R8 read flag", 32'(last_write), 32'h0);
      access(1'b0, 3'd7, 2'd0, 32'h0, 1'b0, ref_read(6'h10, 2'd0, 2'd3), "R5 byte read k3");
      access(1'b0, 3'd6, 2'd1, 32'h0, 1'b0, ref_read(6'h10, 2'd1, 2'd2), "R5 half read k2");
      access(1'b0, 3'd5, 2'd1, 32'h0, 1'b0, ref_read(6'h10, 2'd1, 2'd1), "R5 half read k1");
      access(1'b0, 3'd4, 2'd0, 32'h0, 1'b0, ref_read(6'h10, 2'd0, 2'd0), "R5 byte read k0");

      // second address word, other fields
      ack_delay = 1;
      access(1'b1, 3'd0, 2'd2, 32'h80AB_F7F0, 1'b0, 32'h0, "R1 write addr B");
      access(1'b1, 3'd4, 2'd2, 32'hDEAD_BEEF, 1'b0, 32'h0, "R4 word write B");
      ref_write(6'h3C, 2'd2, 2'd0, 32'hDEAD_BEEF);
      chk({last_bus, last_dev, last_func, last_reg} == {8'hAB, 5'h1E, 3'h7, 6'h3C},
          "R2 fields B", {8'h0, last_bus, last_dev, last_func, last_reg}, {8'h0, 8'hAB, 5'h1E, 3'h7, 6'h3C});
      access(1'b0, 3'd5, 2'd0, 32'h0, 1'b0, ref_read(6'h3C, 2'd0, 2'd1), "R5 byte read B");

      // R6 rejected shapes
      rc = req_count;
      access(1'b0, 3'd7, 2'd1, 32'h0, 1'b1, 32'h0, "R6 half at k3");
      access(1'b1, 3'd6, 2'd2, 32'h1111_1111, 1'b1, 32'h0, "R6 word at k2");
      access(1'b0, 3'd4, 2'd3, 32'h0, 1'b1, 32'h0, "R6 size code 3");
      access(1'b1, 3'd0, 2'd0, 32'h0000_0000, 1'b1, 32'h0, "R6 address byte write");
      access(1'b1, 3'd1, 2'd2, 32'h0000_0000, 1'b1, 32'h0, "R6 address at offset 1");
      chk(req_count == rc, "R6 no request issued", 32'(req_count), 32'(rc));
      access(1'b0, 3'd0, 2'd2, 32'h0, 1'b0, 32'h80AB_F7F0, "R6 address unchanged");

      // R7 disabled
      access(1'b1, 3'd0, 2'd2, 32'h0012_1D40, 1'b0, 32'h0, "R7 clear enable");
      rc = req_count;
      access(1'b0, 3'd6, 2'd1, 32'h0, 1'b0, 32'h0000_FFFF, "R7 disabled half read");
      access(1'b0, 3'd4, 2'd0, 32'h0, 1'b0, 32'h0000_00FF, "R7 disabled byte read");
      access(1'b1, 3'd4, 2'd2, 32'h1234_5678, 1'b0, 32'h0, "R7 disabled write");
      chk(req_count == rc, "R7 no request while disabled", 32'(req_count), 32'(rc));
      access(1'b1, 3'd0, 2'd2, 32'h8012_1D40, 1'b0, 32'h0, "R7 re-enable");
      access(1'b0, 3'd4, 2'd2, 32'h0, 1'b0, ref_read(6'h10, 2'd2, 2'd0), "R7 write was dropped");

      // R9 absent device (number 31 never answers)
      access(1'b1, 3'd0, 2'd2, 32'h8012_F800, 1'b0, 32'h0, "R9 address of absent device");
      access(1'b0, 3'd4, 2'd1, 32'h0, 1'b0, 32'h0000_FFFF, "R9 timeout half read");
      chk(valid_len == TMO, "R9 request held for timeout", 32'(valid_len), 32'(TMO));
      access(1'b1, 3'd4, 2'd0, 32'h0000_0099, 1'b0, 32'h0, "R9 timeout write");
      access(1'b0, 3'd7, 2'd0, 32'h0, 1'b0, 32'h0000_00FF, "R9 timeout byte read k3");
      access(1'b1, 3'd0, 2'd2, 32'h8012_1D40, 1'b0, 32'h0, "R9 back to present device");
      ack_delay = 0;
      access(1'b0, 3'd4, 2'd0, 32'h0, 1'b0, ref_read(6'h10, 2'd0, 2'd0), "R9 recovery read");

      repeat (3) @(negedge clk);
      chk(completions == issued, "R10 one completion per access", 32'(completions), 32'(issued));
      chk(sb_q.size() == 0, "R10 scoreboard drained", 32'(sb_q.size()), 32'h0);

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule